// File: doc/BRIEF.md
# Direction-Constrained Timeslot Switch Controller

This block manages the connection memory of a time-division switch. Each bus stream is a pair of lines that share timeslot numbers: in any timeslot, one line of the pair is sampled by the switch and the other is driven by it. Which line plays which role is held in one direction bit per paired timeslot. Local streams are single lines with no such constraint. Software or a higher-level controller sends connect and disconnect requests. Each request names a source endpoint and a destination endpoint, each given as (local flag, stream, line, timeslot). The block answers every request with a status code.

The first connection that touches a paired timeslot fixes its direction. The partner line then becomes the opposite role in that timeslot, even if nothing is connected to it. A per-timeslot user count tracks how many connections still involve it. When the count falls to zero, the direction is freed. A later connect that needs the other direction is refused while any user remains. The connection memory stores one source per destination, and one source may feed any number of destinations.

The command channel uses valid/ready. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its status appears on `rsp_*` in the next cycle and is held until `rsp_ready` is high. `cmd_ready` equals `!rsp_valid || rsp_ready`, so a stalled response holds back the next command, and a taken response and a new command can share one edge. Two plain read ports let the serial datapath fetch a destination's stored source and a paired timeslot's direction.

Top module: `tsx_conn_ctrl`

## Requirements
- R1: After reset, no destination holds a connection and no paired timeslot has a valid direction.
- R2: `cmd_ready` is `!rsp_valid || rsp_ready`. `rsp_valid` rises in the cycle after a command is accepted. The response stays valid with an unchanged status until a cycle with `rsp_ready` high.
- R3: `rsp_status` encodes granted as 0, blocked as 1 and not-found as 2.
- R4: Direction is encoded as follows. A granted connect whose source is bus line L at timeslot t makes line L the input of that paired timeslot (`dq_in_line`=L). A destination on bus line L makes the partner line 1-L the input.
- R5: A connect that needs the input line opposite to the one currently valid on its paired timeslot returns blocked. It changes neither the connection memory nor any direction.
- R6: A paired timeslot's direction stays valid and unchanged while any connection involves it. It becomes invalid when the last such connection is removed, after which either direction may be set.
- R7: Local endpoints carry no direction. A connect between two local endpoints with a free destination is always granted. The line field of a local endpoint is ignored and is stored as 0.
- R8: A connect to a destination that already holds a connection returns blocked. One source may be connected to several destinations.
- R9: A disconnect whose destination holds a connection from exactly the named source removes it and returns granted. Any other disconnect returns not-found and changes nothing.
- R10: A request naming a stream number at or above the populated count (pairs: `N_PAIR`, locals: `N_LOCAL`) returns not-found and changes nothing.
- R11: A connect whose source and destination are both on the same paired timeslot is granted when they are on opposite lines. It is blocked when they are on the same line.
- R12: The read port reports whether a destination is in use and the source stored for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 1 | 0 connect, 1 disconnect |
| cmd_src_loc | input | 1 | Source is a local stream |
| cmd_src_strm | input | SW | Source stream number |
| cmd_src_line | input | 1 | Source line within a bus pair |
| cmd_src_ts | input | TW | Source timeslot |
| cmd_dst_loc | input | 1 | Destination is a local stream |
| cmd_dst_strm | input | SW | Destination stream number |
| cmd_dst_line | input | 1 | Destination line within a bus pair |
| cmd_dst_ts | input | TW | Destination timeslot |
| rsp_valid | output | 1 | Status available |
| rsp_ready | input | 1 | Status taken |
| rsp_status | output | 2 | Granted, blocked or not-found |
| rd_loc | input | 1 | Read port: destination is local |
| rd_strm | input | SW | Read port: destination stream |
| rd_line | input | 1 | Read port: destination line |
| rd_ts | input | TW | Read port: destination timeslot |
| rd_used | output | 1 | Destination holds a connection |
| rd_src_loc | output | 1 | Stored source local flag |
| rd_src_strm | output | SW | Stored source stream |
| rd_src_line | output | 1 | Stored source line |
| rd_src_ts | output | TW | Stored source timeslot |
| dq_strm | input | SW | Direction query: pair number |
| dq_ts | input | TW | Direction query: timeslot |
| dq_valid | output | 1 | Direction is set for that paired timeslot |
| dq_in_line | output | 1 | Line that is the input (0 when not valid) |

## Verification
Some properties are checked on every cycle. The handshake timing and response hold are checked, as is the rule that a pair of local endpoints is never refused. Out-of-range streams must return not-found. User counts must never wrap, a set direction must never be overwritten by a new user, and direction validity must track a non-zero user count. The connection memory must only fill empty entries and only clear occupied ones. Blocking, fan-out and freeing of a direction after the last release depend on sequences of requests, so only the bench's scenarios show them. The same holds for a not-found disconnect that leaves state untouched and for commands held back behind a stalled response.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

  typedef enum logic [1:0] {
    ST_GRANT    = 2'd0,
    ST_BLOCK    = 2'd1,
    ST_NOTFOUND = 2'd2
  } status_e;

  typedef enum logic {
    OP_CONNECT    = 1'b0,
    OP_DISCONNECT = 1'b1
  } op_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tsx_ep_map.sv
module tsx_ep_map
  import tsx_pkg::*;
#(
  parameter int N_PAIR  = 8,
  parameter int N_LOCAL = 4,
  parameter int N_TS    = 32,
  localparam int SW  = width_of((N_PAIR > N_LOCAL) ? N_PAIR : N_LOCAL),
  localparam int TW  = width_of(N_TS),
  localparam int RIW = width_of(N_PAIR * N_TS)
) (
  input  logic           loc,
  input  logic [SW-1:0]  strm,
  input  logic           line,
  input  logic [TW-1:0]  ts,
  output logic           ok,
  output logic           bus,
  output logic           line_n,
  output logic [RIW-1:0] dir_idx
);

  logic strm_ok;
  logic ts_ok;

  assign strm_ok = loc ? (int'(strm) < N_LOCAL) : (int'(strm) < N_PAIR);
  assign ts_ok   = int'(ts) < N_TS;
  assign ok      = strm_ok && ts_ok;
  assign bus     = ok && !loc;
  // local endpoints have a single line, so the line field is folded to 0
  assign line_n  = loc ? 1'b0 : line;
  assign dir_idx = bus ? RIW'(int'(strm) * N_TS + int'(ts)) : '0;

endmodule

// File: rtl/tsx_conn_mem.sv
module tsx_conn_mem
  import tsx_pkg::*;
#(
  parameter int N_ENT = 640,
  parameter int EW    = 10,
  localparam int IW   = width_of(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [IW-1:0] w_idx,
  input  logic [EW-1:0] w_src,
  input  logic [IW-1:0] l_idx,
  output logic          l_used,
  output logic [EW-1:0] l_src,
  input  logic [IW-1:0] r_idx,
  output logic          r_used,
  output logic [EW-1:0] r_src
);

  logic          used_q [N_ENT];
  logic [EW-1:0] src_q  [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) used_q[i] <= 1'b0;
    end else if (set_en) begin
      used_q[w_idx] <= 1'b1;
    end else if (clr_en) begin
      used_q[w_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) src_q[w_idx] <= w_src;
  end

  assign l_used = used_q[l_idx];
  assign l_src  = src_q[l_idx];
  assign r_used = used_q[r_idx];
  assign r_src  = src_q[r_idx];

  // R8
  set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !used_q[w_idx]);

  // R9
  clr_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> used_q[w_idx]);

  // R9
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));

endmodule

// File: rtl/tsx_dir_table.sv
module tsx_dir_table
  import tsx_pkg::*;
#(
  parameter int N_ENT     = 256,
  parameter int MAX_USERS = 641,
  localparam int IW = width_of(N_ENT),
  localparam int CW = width_of(MAX_USERS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_conn,
  input  logic          a_en,
  input  logic [IW-1:0] a_idx,
  input  logic          a_dir,
  input  logic          b_en,
  input  logic [IW-1:0] b_idx,
  input  logic          b_dir,
  output logic          a_vld,
  output logic          a_cur,
  output logic          b_vld,
  output logic          b_cur,
  input  logic [IW-1:0] q_idx,
  output logic          q_vld,
  output logic          q_dir
);

  logic          vld_q [N_ENT];
  logic          dir_q [N_ENT];
  logic [CW-1:0] cnt_q [N_ENT];

  logic          same;
  logic [CW-1:0] cnt_a, cnt_b, step_a, nxt_a, nxt_b;

  assign same   = a_en && b_en && (a_idx == b_idx);
  assign cnt_a  = cnt_q[a_idx];
  assign cnt_b  = cnt_q[b_idx];
  assign step_a = same ? CW'(2) : CW'(1);
  assign nxt_a  = upd_conn ? (cnt_a + step_a) : (cnt_a - step_a);
  assign nxt_b  = upd_conn ? (cnt_b + CW'(1)) : (cnt_b - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        vld_q[i] <= 1'b0;
        dir_q[i] <= 1'b0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (a_en) begin
        cnt_q[a_idx] <= nxt_a;
        vld_q[a_idx] <= (nxt_a != '0);
        if (upd_conn) dir_q[a_idx] <= a_dir;
      end
      if (b_en && !same) begin
        cnt_q[b_idx] <= nxt_b;
        vld_q[b_idx] <= (nxt_b != '0);
        if (upd_conn) dir_q[b_idx] <= b_dir;
      end
    end
  end

  assign a_vld = vld_q[a_idx];
  assign a_cur = dir_q[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_cur = dir_q[b_idx];
  assign q_vld = vld_q[q_idx];
  assign q_dir = dir_q[q_idx];

  // R6
  dir_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && upd_conn && vld_q[a_idx]) |-> (dir_q[a_idx] == a_dir));

  // R6
  dir_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && upd_conn && vld_q[b_idx]) |-> (dir_q[b_idx] == b_dir));

  // R11
  same_slot_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same && upd_conn) |-> (a_dir == b_dir));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !upd_conn) |-> (cnt_a >= step_a));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && upd_conn) |-> ((int'(cnt_a) + int'(step_a)) <= MAX_USERS));

  // R6
  vld_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld == (cnt_q[q_idx] != '0));

endmodule

// File: rtl/tsx_decide.sv
module tsx_decide
  import tsx_pkg::*;
(
  input  logic    go,
  input  op_e     op,
  input  logic    s_ok,
  input  logic    d_ok,
  input  logic    s_bus,
  input  logic    d_bus,
  input  logic    s_line,
  input  logic    d_line,
  input  logic    same_slot,
  input  logic    a_vld,
  input  logic    a_cur,
  input  logic    b_vld,
  input  logic    b_cur,
  input  logic    d_used,
  input  logic    src_match,
  output status_e status,
  output logic    cm_set,
  output logic    cm_clr,
  output logic    ua_en,
  output logic    ub_en,
  output logic    upd_conn,
  output logic    ua_dir,
  output logic    ub_dir
);

  logic need_s, need_d;
  logic s_clash, d_clash, slot_clash, grant;

  // input line demanded by each end: a source is read on its own line,
  // a destination is driven on its line so the partner must be the input
  assign need_s     = s_line;
  assign need_d     = ~d_line;
  assign s_clash    = s_bus && a_vld && (a_cur != need_s);
  assign d_clash    = d_bus && b_vld && (b_cur != need_d);
  assign slot_clash = same_slot && (need_s != need_d);

  always_comb begin
    status = ST_GRANT;
    if (!(s_ok && d_ok)) begin
      status = ST_NOTFOUND;
    end else if (op == OP_CONNECT) begin
      if (d_used || s_clash || d_clash || slot_clash) status = ST_BLOCK;
    end else if (!d_used || !src_match) begin
      status = ST_NOTFOUND;
    end
  end

  assign grant    = go && (status == ST_GRANT);
  assign cm_set   = grant && (op == OP_CONNECT);
  assign cm_clr   = grant && (op == OP_DISCONNECT);
  assign ua_en    = grant && s_bus;
  assign ub_en    = grant && d_bus;
  assign upd_conn = (op == OP_CONNECT);
  assign ua_dir   = need_s;
  assign ub_dir   = need_d;

endmodule

// File: rtl/tsx_conn_ctrl.sv
module tsx_conn_ctrl
  import tsx_pkg::*;
#(
  parameter int N_PAIR  = 8,
  parameter int N_LOCAL = 4,
  parameter int N_TS    = 32,
  localparam int SW = width_of((N_PAIR > N_LOCAL) ? N_PAIR : N_LOCAL),
  localparam int TW = width_of(N_TS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic          cmd_src_loc,
  input  logic [SW-1:0] cmd_src_strm,
  input  logic          cmd_src_line,
  input  logic [TW-1:0] cmd_src_ts,
  input  logic          cmd_dst_loc,
  input  logic [SW-1:0] cmd_dst_strm,
  input  logic          cmd_dst_line,
  input  logic [TW-1:0] cmd_dst_ts,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_status,
  input  logic          rd_loc,
  input  logic [SW-1:0] rd_strm,
  input  logic          rd_line,
  input  logic [TW-1:0] rd_ts,
  output logic          rd_used,
  output logic          rd_src_loc,
  output logic [SW-1:0] rd_src_strm,
  output logic          rd_src_line,
  output logic [TW-1:0] rd_src_ts,
  input  logic [SW-1:0] dq_strm,
  input  logic [TW-1:0] dq_ts,
  output logic          dq_valid,
  output logic          dq_in_line
);

  localparam int NDST = (2 * N_PAIR + N_LOCAL) * N_TS;
  localparam int NDIR = N_PAIR * N_TS;
  localparam int DIW  = width_of(NDST);
  localparam int RIW  = width_of(NDIR);
  localparam int EW   = SW + TW + 2;

  function automatic logic [DIW-1:0] dst_index(input logic loc, input logic [SW-1:0] s,
                                               input logic ln, input logic [TW-1:0] t);
    int i;
    if (loc) i = 2 * N_PAIR * N_TS + int'(s) * N_TS + int'(t);
    else     i = (int'(s) * 2 + int'(ln)) * N_TS + int'(t);
    return DIW'(i);
  endfunction

  op_e            op;
  logic           fire;
  logic           s_ok, s_bus, s_line, d_ok, d_bus, d_line;
  logic [RIW-1:0] s_didx, d_didx;
  logic [EW-1:0]  src_enc, d_src_stored, r_src;
  logic [DIW-1:0] d_cidx, r_cidx;
  logic           d_used_raw, d_used, src_match, same_slot;
  logic           a_vld, a_cur, b_vld, b_cur, q_vld, q_dir;
  status_e        status_n;
  logic           cm_set, cm_clr, ua_en, ub_en, upd_conn, ua_dir, ub_dir;
  logic           rd_ok, r_used, dq_ok;
  logic [RIW-1:0] q_idx;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  tsx_ep_map #(.N_PAIR(N_PAIR), .N_LOCAL(N_LOCAL), .N_TS(N_TS)) u_src_map (
    .loc(cmd_src_loc), .strm(cmd_src_strm), .line(cmd_src_line), .ts(cmd_src_ts),
    .ok(s_ok), .bus(s_bus), .line_n(s_line), .dir_idx(s_didx)
  );

  tsx_ep_map #(.N_PAIR(N_PAIR), .N_LOCAL(N_LOCAL), .N_TS(N_TS)) u_dst_map (
    .loc(cmd_dst_loc), .strm(cmd_dst_strm), .line(cmd_dst_line), .ts(cmd_dst_ts),
    .ok(d_ok), .bus(d_bus), .line_n(d_line), .dir_idx(d_didx)
  );

  assign src_enc   = {cmd_src_loc, cmd_src_strm, s_line, cmd_src_ts};
  assign d_cidx    = d_ok ? dst_index(cmd_dst_loc, cmd_dst_strm, d_line, cmd_dst_ts) : '0;
  assign d_used    = d_used_raw && d_ok;
  assign src_match = (d_src_stored == src_enc);
  assign same_slot = s_bus && d_bus && (s_didx == d_didx);

  assign rd_ok  = (rd_loc ? (int'(rd_strm) < N_LOCAL) : (int'(rd_strm) < N_PAIR))
                  && (int'(rd_ts) < N_TS);
  assign r_cidx = rd_ok ? dst_index(rd_loc, rd_strm, rd_loc ? 1'b0 : rd_line, rd_ts) : '0;

  tsx_conn_mem #(.N_ENT(NDST), .EW(EW)) u_cmem (
    .clk(clk), .rst_n(rst_n),
    .set_en(cm_set), .clr_en(cm_clr), .w_idx(d_cidx), .w_src(src_enc),
    .l_idx(d_cidx), .l_used(d_used_raw), .l_src(d_src_stored),
    .r_idx(r_cidx), .r_used(r_used), .r_src(r_src)
  );

  assign dq_ok = (int'(dq_strm) < N_PAIR) && (int'(dq_ts) < N_TS);
  assign q_idx = dq_ok ? RIW'(int'(dq_strm) * N_TS + int'(dq_ts)) : '0;

  tsx_dir_table #(.N_ENT(NDIR), .MAX_USERS(NDST + 1)) u_dir (
    .clk(clk), .rst_n(rst_n), .upd_conn(upd_conn),
    .a_en(ua_en), .a_idx(s_didx), .a_dir(ua_dir),
    .b_en(ub_en), .b_idx(d_didx), .b_dir(ub_dir),
    .a_vld(a_vld), .a_cur(a_cur), .b_vld(b_vld), .b_cur(b_cur),
    .q_idx(q_idx), .q_vld(q_vld), .q_dir(q_dir)
  );

  tsx_decide u_decide (
    .go(fire), .op(op), .s_ok(s_ok), .d_ok(d_ok), .s_bus(s_bus), .d_bus(d_bus),
    .s_line(s_line), .d_line(d_line), .same_slot(same_slot),
    .a_vld(a_vld), .a_cur(a_cur), .b_vld(b_vld), .b_cur(b_cur),
    .d_used(d_used), .src_match(src_match), .status(status_n),
    .cm_set(cm_set), .cm_clr(cm_clr), .ua_en(ua_en), .ub_en(ub_en),
    .upd_conn(upd_conn), .ua_dir(ua_dir), .ub_dir(ub_dir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_GRANT;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_status <= status_n;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign rd_used     = r_used && rd_ok;
  assign rd_src_loc  = r_src[EW-1];
  assign rd_src_strm = r_src[EW-2 -: SW];
  assign rd_src_line = r_src[TW];
  assign rd_src_ts   = r_src[TW-1:0];
  assign dq_valid    = q_vld && dq_ok;
  assign dq_in_line  = q_dir && dq_valid;

  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  // R7
  local_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_CONNECT && s_ok && d_ok && !s_bus && !d_bus && !d_used)
      |=> (rsp_status == ST_GRANT));

  // R10
  range_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(s_ok && d_ok)) |=> (rsp_status == ST_NOTFOUND));

endmodule

// File: tb/tsx_conn_ctrl_test.sv
`timescale 1ns/1ps
module tsx_conn_ctrl_test;

  localparam int NP = 8, NL = 4, NT = 32;
  localparam int NDST = (2 * NP + NL) * NT;
  localparam int NDIR = NP * NT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_op = 0;
  logic cmd_src_loc = 0, cmd_src_line = 0, cmd_dst_loc = 0, cmd_dst_line = 0;
  logic [2:0] cmd_src_strm = 0, cmd_dst_strm = 0;
  logic [4:0] cmd_src_ts = 0, cmd_dst_ts = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [1:0] rsp_status;
  logic rd_loc = 0, rd_line = 0;
  logic [2:0] rd_strm = 0;
  logic [4:0] rd_ts = 0;
  logic rd_used, rd_src_loc, rd_src_line;
  logic [2:0] rd_src_strm;
  logic [4:0] rd_src_ts;
  logic [2:0] dq_strm = 0;
  logic [4:0] dq_ts = 0;
  logic dq_valid, dq_in_line;

  int n_chk = 0, n_fail = 0;

  // model state
  bit m_used [NDST];
  int m_src  [NDST];
  bit m_vld  [NDIR];
  bit m_dir  [NDIR];
  int m_cnt  [NDIR];

  always #2.5 clk = ~clk;

  tsx_conn_ctrl uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ep_ok(input bit loc, input int s, input int t);
    return (loc ? (s < NL) : (s < NP)) && (t < NT);
  endfunction

  function automatic int didx(input bit loc, input int s, input bit ln, input int t);
    return loc ? (2 * NP * NT + s * NT + t) : ((s * 2 + ln) * NT + t);
  endfunction

  function automatic int enc(input bit loc, input int s, input bit ln, input int t);
    return (int'(loc) << 9) | (s << 6) | (int'(loc ? 1'b0 : ln) << 5) | t;
  endfunction

  // expected status (R3 codes: 0 grant, 1 block, 2 not-found) and model update
  task automatic model_apply(input bit op, input bit sl, input int ss, input bit sln, input int st,
                             input bit dl, input int ds, input bit dln, input int dt, output int st_o);
    int di, si, ri;
    bit sb, db, ns, nd;
    st_o = 0;
    if (!ep_ok(sl, ss, st) || !ep_ok(dl, ds, dt)) begin st_o = 2; return; end
    sb = !sl; db = !dl;
    ns = sln; nd = !dln;
    di = didx(dl, ds, dl ? 1'b0 : dln, dt);
    si = ss * NT + st; ri = ds * NT + dt;
    if (op == 1'b0) begin
      if (m_used[di]) st_o = 1;
      else if (sb && m_vld[si] && m_dir[si] != ns) st_o = 1;
      else if (db && m_vld[ri] && m_dir[ri] != nd) st_o = 1;
      else if (sb && db && si == ri && ns != nd) st_o = 1;
      if (st_o == 0) begin
        m_used[di] = 1; m_src[di] = enc(sl, ss, sln, st);
        if (sb) begin m_cnt[si]++; m_vld[si] = 1; m_dir[si] = ns; end
        if (db) begin m_cnt[ri]++; m_vld[ri] = 1; m_dir[ri] = nd; end
      end
    end else begin
      if (!m_used[di] || m_src[di] != enc(sl, ss, sln, st)) begin st_o = 2; return; end
      m_used[di] = 0;
      if (sb) begin m_cnt[si]--; if (m_cnt[si] == 0) m_vld[si] = 0; end
      if (db) begin m_cnt[ri]--; if (m_cnt[ri] == 0) m_vld[ri] = 0; end
    end
  endtask

  task automatic drive(input bit op, input bit sl, input int ss, input bit sln, input int st,
                       input bit dl, input int ds, input bit dln, input int dt);
    cmd_op = op;
    cmd_src_loc = sl; cmd_src_strm = 3'(ss); cmd_src_line = sln; cmd_src_ts = 5'(st);
    cmd_dst_loc = dl; cmd_dst_strm = 3'(ds); cmd_dst_line = dln; cmd_dst_ts = 5'(dt);
    cmd_valid = 1'b1;
  endtask

  task automatic read_dst(input bit loc, input int s, input bit ln, input int t);
    int i, e;
    rd_loc = loc; rd_strm = 3'(s); rd_line = ln; rd_ts = 5'(t);
    #1;
    if (!ep_ok(loc, s, t)) begin
      check(rd_used == 1'b0, "R10 read out of range", int'(rd_used), 0);
      return;
    end
    i = didx(loc, s, loc ? 1'b0 : ln, t);
    check(rd_used == m_used[i], "R12 used flag", int'(rd_used), int'(m_used[i]));
    if (m_used[i]) begin
      e = int'({rd_src_loc, rd_src_strm, rd_src_line, rd_src_ts});
      check(e == m_src[i], "R12 stored source", e, m_src[i]);
    end
  endtask

  task automatic read_dir(input int s, input int t);
    int i;
    bit ev, el;
    if (s >= NP) return;
    dq_strm = 3'(s); dq_ts = 5'(t);
    #1;
    i = s * NT + t;
    ev = m_vld[i]; el = m_vld[i] ? m_dir[i] : 1'b0;
    check(dq_valid == ev, "R6 direction valid", int'(dq_valid), int'(ev));
    check(dq_in_line == el, "R4 input line", int'(dq_in_line), int'(el));
  endtask

  task automatic do_op(input bit op, input bit sl, input int ss, input bit sln, input int st,
                       input bit dl, input int ds, input bit dln, input int dt,
                       input int want, input string tag, input bit bp);
    int exp, got, hold;
    model_apply(op, sl, ss, sln, st, dl, ds, dln, dt, exp);
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(op, sl, ss, sln, st, dl, ds, dln, dt);
    check(cmd_ready == 1'b1, "R2 ready when idle", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid == 1'b1, "R2 response next cycle", int'(rsp_valid), 1);
    got = int'(rsp_status);
    hold = bp ? int'($urandom % 3) : 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && int'(rsp_status) == got && !cmd_ready, "R2 held under back-pressure",
            int'(rsp_status), got);
    end
    check(got == exp, {"R3 status ", tag}, got, exp);
    if (want >= 0) check(got == want, {"directed ", tag}, got, want);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R2 response taken", int'(rsp_valid), 0);
    read_dst(dl, ds, dln, dt);
    if (!sl) read_dir(ss, st);
    if (!dl) read_dir(ds, dt);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int errs, st, o, s_s, d_s, s_t, d_t, di;
    bit sl, dl, sln, dln;
    void'($urandom(32'd1234));
    for (int i = 0; i < NDST; i++) begin m_used[i] = 0; m_src[i] = 0; end
    for (int i = 0; i < NDIR; i++) begin m_vld[i] = 0; m_dir[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: sweep every destination and every paired timeslot
    errs = 0;
    for (int s = 0; s < NP; s++)
      for (int t = 0; t < NT; t++) begin
        dq_strm = 3'(s); dq_ts = 5'(t);
        for (int ln = 0; ln < 2; ln++) begin
          rd_loc = 0; rd_strm = 3'(s); rd_line = ln[0]; rd_ts = 5'(t);
          #1; if (rd_used || dq_valid) errs++;
        end
      end
    for (int s = 0; s < NL; s++)
      for (int t = 0; t < NT; t++) begin
        rd_loc = 1; rd_strm = 3'(s); rd_ts = 5'(t);
        #1; if (rd_used) errs++;
      end
    check(errs == 0, "R1 reset state clear", errs, 0);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

    // R4: first use fixes direction from the source line
    do_op(0, 0, 0, 0, 5, 1, 0, 0, 5, 0, "R4 first connect", 0);
    // R5: destination on line 0 needs input line 1
    do_op(0, 1, 1, 0, 5, 0, 0, 0, 5, 1, "R5 opposite direction", 0);
    // R8: fan-out allowed, occupied destination blocked
    do_op(0, 0, 0, 0, 5, 1, 1, 0, 6, 0, "R8 fan-out", 0);
    do_op(0, 1, 2, 0, 0, 1, 0, 0, 5, 1, "R8 destination busy", 0);
    // R9: mismatched source
    do_op(1, 1, 2, 0, 0, 1, 0, 0, 5, 2, "R9 wrong source", 0);
    // R6: direction survives first release, cleared by last
    do_op(1, 0, 0, 0, 5, 1, 0, 0, 5, 0, "R6 release one", 0);
    do_op(1, 0, 0, 0, 5, 1, 1, 0, 6, 0, "R6 release last", 0);
    do_op(0, 1, 1, 0, 5, 0, 0, 0, 5, 0, "R6 reversed after free", 0);
    // R9: nonexistent connection
    do_op(1, 1, 3, 0, 9, 1, 2, 0, 9, 2, "R9 absent", 0);
    // R11: same paired slot
    do_op(0, 0, 1, 0, 7, 0, 1, 1, 7, 0, "R11 opposite lines", 0);
    do_op(0, 0, 2, 0, 8, 0, 2, 0, 8, 1, "R11 same line", 0);
    do_op(1, 0, 1, 0, 7, 0, 1, 1, 7, 0, "R11 release both ends", 0);
    // R10: stream above populated local count
    do_op(0, 1, 6, 0, 1, 1, 0, 0, 1, 2, "R10 bad source stream", 0);
    do_op(0, 1, 0, 0, 1, 1, 5, 0, 1, 2, "R10 bad destination stream", 0);
    // R7: local line bit ignored
    do_op(0, 1, 0, 1, 9, 1, 3, 1, 9, 0, "R7 local pair", 0);
    read_dst(1, 3, 0, 9);

    // R2: command held back behind a stalled response, then shares the edge
    @(negedge clk);
    drive(0, 1, 0, 0, 20, 1, 1, 0, 20);
    model_apply(0, 1, 0, 0, 20, 1, 1, 0, 20, st);
    @(negedge clk);
    drive(0, 1, 0, 0, 21, 1, 1, 0, 21);
    check(cmd_ready == 1'b0, "R2 stalled ready low", int'(cmd_ready), 0);
    @(negedge clk);
    check(cmd_ready == 1'b0 && rsp_valid, "R2 stall persists", int'(cmd_ready), 0);
    read_dst(1, 1, 0, 21);
    check(int'(rsp_status) == st, "R2 first status", int'(rsp_status), st);
    rsp_ready = 1'b1;
    model_apply(0, 1, 0, 0, 21, 1, 1, 0, 21, st);
    @(negedge clk);
    cmd_valid = 1'b0; rsp_ready = 1'b0;
    check(rsp_valid == 1'b1 && int'(rsp_status) == st, "R2 second status", int'(rsp_status), st);
    read_dst(1, 1, 0, 21);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // constrained random mix
    for (int n = 0; n < 700; n++) begin
      o = ($urandom % 100) < 55 ? 0 : 1;
      dl = ($urandom % 3) == 0;
      d_s = dl ? (($urandom % 12 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 2))
               : int'($urandom % 2);
      dln = $urandom % 2;
      d_t = $urandom % 3;
      sl = ($urandom % 3) == 0;
      s_s = sl ? int'($urandom % 2) : int'($urandom % 2);
      sln = $urandom % 2;
      s_t = $urandom % 3;
      if (o == 1 && ep_ok(dl, d_s, d_t)) begin
        di = didx(dl, d_s, dl ? 1'b0 : dln, d_t);
        if (m_used[di] && ($urandom % 4) != 0) begin
          sl = m_src[di][9]; s_s = (m_src[di] >> 6) & 7;
          sln = m_src[di][5]; s_t = m_src[di] & 31;
        end
      end
      do_op(o[0], sl, s_s, sln, s_t, dl, d_s, dln, d_t, -1, "R5 R8 R9 random", 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule